// File: doc/BRIEF.md
# Port-Based VLAN Forwarding Filter

This block sits in the forwarding path of a small layer-2 switch. For every received frame it works out the set of egress ports. Each frame arrives as a descriptor that carries the ingress port index, the destination port index from the address lookup, a flood flag for unknown destinations and a broadcast/multicast flag. Each port owns a membership mask with one bit per port, and the mask limits where that port's frames may go. A single switch-wide isolation control decides what happens to a known unicast frame whose destination lies outside the sender's mask. When the control is set, the frame is discarded. When it is clear, the frame is forwarded anyway.

With the reset settings, the last port acts as a shared uplink. Every other port may reach only itself and the uplink, so each of the lower ports forms its own VLAN with the uplink, and the uplink reaches all ports. Software or a strap sequencer reprograms the masks and the control through a plain address/data/write-enable port. The result is a one-hot-per-port egress mask plus a drop flag. It is registered behind a valid/ready handshake, one clock after the descriptor is accepted.

Top module: `vlan_egress_filter`

## Requirements
- R1: After reset, with ports indexed from 0 and mask bit i meaning port i, port i below NUM_PORTS-1 holds a mask with only bit i and bit NUM_PORTS-1 set. Port NUM_PORTS-1 holds all ones, and the isolation control is 1. With three ports the masks are 3'b101, 3'b110 and 3'b111.
- R2: A descriptor with the flood flag or the broadcast/multicast flag set produces the source port's mask with the source port's own bit cleared. The isolation control does not affect this result.
- R3: A unicast descriptor (both flags 0) whose destination bit is set in the source port's mask, with the destination different from the source, produces a mask with only the destination bit set.
- R4: With the isolation control at 1, a unicast descriptor whose destination bit is clear in the source port's mask produces an all-zero mask.
- R5: With the isolation control at 0, a unicast descriptor whose destination bit is clear in the source port's mask is still forwarded, and the mask has only the destination bit set.
- R6: The egress mask never contains the source port. A unicast descriptor whose destination equals its source yields an all-zero mask.
- R7: `egr_drop` is 1 exactly when the delivered `egr_mask` is all zero.
- R8: A write with `cfg_addr` equal to a port index in 0..NUM_PORTS-1 loads that port's mask from `cfg_wdata`. A write with `cfg_addr` equal to NUM_PORTS loads the isolation control from `cfg_wdata[0]`. A write to any higher address changes nothing. A descriptor accepted in the same cycle as a write uses the old settings, and one accepted in any later cycle uses the new ones.
- R9: A descriptor is accepted when `desc_valid` and `desc_ready` are both 1. Its result appears on `egr_valid`/`egr_mask`/`egr_drop` in the next cycle. The result holds unchanged while `egr_ready` is 0. `desc_ready` is 0 only while a result is waiting and `egr_ready` is 0.
- R10: A source or destination index of NUM_PORTS or more yields an all-zero mask. For the destination this applies to unicast descriptors only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | CFG_AW | Configuration address: port masks, then the control |
| cfg_wdata | input | NUM_PORTS | Configuration write data |
| desc_valid | input | 1 | Descriptor valid |
| desc_ready | output | 1 | Descriptor can be accepted |
| desc_src | input | PORT_W | Ingress port index |
| desc_dst | input | PORT_W | Destination port index from lookup |
| desc_flood | input | 1 | Destination unknown, flood |
| desc_bcast | input | 1 | Broadcast or multicast frame |
| egr_valid | output | 1 | Result valid |
| egr_ready | input | 1 | Result consumer ready |
| egr_mask | output | NUM_PORTS | Egress port set, bit i = port i |
| egr_drop | output | 1 | Frame discarded (empty mask) |

## Verification
The bench builds the block with its defaults: NUM_PORTS = 3, a two-bit port index and CFG_AW = 3. With these values the unused index 3 is available on both descriptor fields for the out-of-range cases. The address space also has room above the control register (address 5), which tests that writes to unused addresses change nothing. Three ports are enough to reach every relation between source, destination and uplink: member, non-member, self, and shared uplink. The bench also exercises the write that lands in the same cycle as an accepted descriptor, and holds the output stalled for several cycles.

// File: rtl/vlan_filt_pkg.sv
// Package vlan_filt_pkg
// Shared definitions for the VLAN egress filter: the classification of a
// descriptor and the computation of the reset membership masks.
// Assumes at most 32 ports (the reset helper works on 32-bit values).
package vlan_filt_pkg;

    // How a descriptor is handled by the egress calculation.
    typedef enum logic [1:0] {
        FWD_FLOOD   = 2'd0,  // flood / broadcast / multicast
        FWD_MEMBER  = 2'd1,  // unicast inside the sender's mask
        FWD_FOREIGN = 2'd2,  // unicast outside the sender's mask
        FWD_INVALID = 2'd3   // bad index or self-addressed
    } fwd_kind_e;

    // Reset mask of port idx: itself plus the uplink (last port); the
    // uplink itself reaches every port.
    function automatic logic [31:0] reset_mask(int unsigned n, int unsigned idx);
        if (idx == n - 1) begin
            return (32'd1 << n) - 32'd1;
        end
        return (32'd1 << idx) | (32'd1 << (n - 1));
    endfunction

endpackage

// File: rtl/vlan_mask_regs.sv
// Module vlan_mask_regs
// Holds one membership mask per port plus the isolation control bit.
// Addresses 0..NUM_PORTS-1 select a port mask, NUM_PORTS selects the
// control (data bit 0); anything higher is ignored. Writes land on the
// clock edge, so a value read in the write cycle is still the old one.
module vlan_mask_regs #(
    parameter int unsigned NUM_PORTS = 3,
    parameter int unsigned CFG_AW    = 3
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                we,
    input  logic [CFG_AW-1:0]                   addr,
    input  logic [NUM_PORTS-1:0]                wdata,
    output logic [NUM_PORTS-1:0][NUM_PORTS-1:0] masks,
    output logic                                isolate
);

    localparam logic [CFG_AW-1:0] CTRL_ADDR = CFG_AW'(NUM_PORTS);

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
        localparam logic [NUM_PORTS-1:0] RST_VAL =
            NUM_PORTS'(vlan_filt_pkg::reset_mask(NUM_PORTS, g));
        localparam logic [CFG_AW-1:0] MY_ADDR = CFG_AW'(g);

        // Purpose: load or reset this port's membership mask.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                masks[g] <= RST_VAL;
            end else if (we && (addr == MY_ADDR)) begin
                masks[g] <= wdata;
            end
        end
    end

    // Purpose: load or reset the switch-wide isolation control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isolate <= 1'b1;
        end else if (we && (addr == CTRL_ADDR)) begin
            isolate <= wdata[0];
        end
    end

endmodule

// File: rtl/vlan_egress_calc.sv
// Module vlan_egress_calc
// Combinational egress decision for one descriptor. Decodes the source and
// destination indices against the port count, classifies the frame and
// forms the egress mask; the source port is always removed. An index at or
// above NUM_PORTS decodes to no port and leads to an empty mask.
module vlan_egress_calc #(
    parameter int unsigned NUM_PORTS = 3,
    parameter int unsigned PORT_W    = 2
) (
    input  logic [NUM_PORTS-1:0][NUM_PORTS-1:0] masks,
    input  logic                                isolate,
    input  logic [PORT_W-1:0]                   src,
    input  logic [PORT_W-1:0]                   dst,
    input  logic                                flood,
    input  logic                                bcast,
    output logic [NUM_PORTS-1:0]                egress,
    output logic                                drop
);
    import vlan_filt_pkg::*;

    logic [NUM_PORTS-1:0] src_mask;
    logic [NUM_PORTS-1:0] src_bit;
    logic [NUM_PORTS-1:0] dst_bit;
    fwd_kind_e            kind;

    // Purpose: decode indices into one-hot bits and pick the sender's mask.
    always_comb begin
        src_mask = '0;
        src_bit  = '0;
        dst_bit  = '0;
        for (int i = 0; i < NUM_PORTS; i++) begin
            if (src == PORT_W'(i)) begin
                src_mask   = masks[i];
                src_bit[i] = 1'b1;
            end
            if (dst == PORT_W'(i)) begin
                dst_bit[i] = 1'b1;
            end
        end
    end

    // Purpose: classify the descriptor.
    always_comb begin
        if (src_bit == '0) begin
            kind = FWD_INVALID;
        end else if (flood || bcast) begin
            kind = FWD_FLOOD;
        end else if ((dst_bit == '0) || ((dst_bit & src_bit) != '0)) begin
            kind = FWD_INVALID;
        end else if ((src_mask & dst_bit) != '0) begin
            kind = FWD_MEMBER;
        end else begin
            kind = FWD_FOREIGN;
        end
    end

    // Purpose: form the egress set from the classification.
    always_comb begin
        unique case (kind)
            FWD_FLOOD:   egress = src_mask & ~src_bit;
            FWD_MEMBER:  egress = dst_bit;
            FWD_FOREIGN: egress = isolate ? '0 : dst_bit;
            default:     egress = '0;
        endcase
        drop = (egress == '0);
    end

endmodule

// File: rtl/vlan_result_stage.sv
// Module vlan_result_stage
// One-entry output register with valid/ready on both sides. A new result is
// taken whenever the slot is empty or being emptied in the same cycle; a
// waiting result holds still while the consumer stalls.
module vlan_result_stage #(
    parameter int unsigned NUM_PORTS = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [NUM_PORTS-1:0] in_mask,
    input  logic                 in_drop,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [NUM_PORTS-1:0] out_mask,
    output logic                 out_drop
);

    // Purpose: the slot can take data unless it is full and stalled.
    always_comb begin
        in_ready = !out_valid || out_ready;
    end

    // Purpose: capture a result or hold the waiting one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_mask  <= '0;
            out_drop  <= 1'b0;
        end else if (in_ready) begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_mask <= in_mask;
                out_drop <= in_drop;
            end
        end
    end

endmodule

// File: rtl/vlan_egress_filter.sv
// Module vlan_egress_filter
// Top of the port-based VLAN egress filter. Configuration registers feed a
// combinational decision whose result is registered behind a handshake,
// giving one cycle from acceptance to result. Assumes NUM_PORTS >= 2 and
// that CFG_AW can address NUM_PORTS.
module vlan_egress_filter #(
    parameter int unsigned NUM_PORTS = 3,
    parameter int unsigned CFG_AW    = 3,
    localparam int unsigned PORT_W   = $clog2(NUM_PORTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [CFG_AW-1:0]    cfg_addr,
    input  logic [NUM_PORTS-1:0] cfg_wdata,
    input  logic                 desc_valid,
    output logic                 desc_ready,
    input  logic [PORT_W-1:0]    desc_src,
    input  logic [PORT_W-1:0]    desc_dst,
    input  logic                 desc_flood,
    input  logic                 desc_bcast,
    output logic                 egr_valid,
    input  logic                 egr_ready,
    output logic [NUM_PORTS-1:0] egr_mask,
    output logic                 egr_drop
);

    logic [NUM_PORTS-1:0][NUM_PORTS-1:0] masks;
    logic                                isolate;
    logic [NUM_PORTS-1:0]                calc_mask;
    logic                                calc_drop;

    vlan_mask_regs #(
        .NUM_PORTS (NUM_PORTS),
        .CFG_AW    (CFG_AW)
    ) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .addr    (cfg_addr),
        .wdata   (cfg_wdata),
        .masks   (masks),
        .isolate (isolate)
    );

    vlan_egress_calc #(
        .NUM_PORTS (NUM_PORTS),
        .PORT_W    (PORT_W)
    ) calc_i (
        .masks   (masks),
        .isolate (isolate),
        .src     (desc_src),
        .dst     (desc_dst),
        .flood   (desc_flood),
        .bcast   (desc_bcast),
        .egress  (calc_mask),
        .drop    (calc_drop)
    );

    vlan_result_stage #(
        .NUM_PORTS (NUM_PORTS)
    ) stage_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (desc_valid),
        .in_ready  (desc_ready),
        .in_mask   (calc_mask),
        .in_drop   (calc_drop),
        .out_valid (egr_valid),
        .out_ready (egr_ready),
        .out_mask  (egr_mask),
        .out_drop  (egr_drop)
    );

endmodule

// File: rtl/vlan_egress_filter_chk.sv
// Module vlan_egress_filter_chk
// Protocol and result checks for vlan_egress_filter, attached by bind.
// Keeps a record of the last accepted source and flags.
module vlan_egress_filter_chk #(
    parameter int unsigned NUM_PORTS = 3,
    parameter int unsigned PORT_W    = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 desc_valid,
    input logic                 desc_ready,
    input logic [PORT_W-1:0]    desc_src,
    input logic                 desc_flood,
    input logic                 desc_bcast,
    input logic                 egr_valid,
    input logic                 egr_ready,
    input logic [NUM_PORTS-1:0] egr_mask,
    input logic                 egr_drop
);

    logic                 accept;
    logic [NUM_PORTS-1:0] src_oh_q;
    logic                 multi_q;

    assign accept = desc_valid && desc_ready;

    // Purpose: remember the source and flood state of the accepted descriptor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_oh_q <= '0;
            multi_q  <= 1'b0;
        end else if (accept) begin
            src_oh_q <= {{(NUM_PORTS-1){1'b0}}, 1'b1} << desc_src;
            multi_q  <= desc_flood || desc_bcast;
        end
    end

    // R9
    accept_to_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> egr_valid);

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (egr_valid && !egr_ready) |=> (egr_valid && $stable(egr_mask) && $stable(egr_drop)));

    // R9
    empty_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !egr_valid |-> desc_ready);

    // R6
    no_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
        egr_valid |-> ((egr_mask & src_oh_q) == '0));

    // R7
    drop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        egr_valid |-> (egr_drop == (egr_mask == '0)));

    // R3
    unicast_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (egr_valid && !multi_q) |-> ($countones(egr_mask) <= 1));

endmodule

bind vlan_egress_filter vlan_egress_filter_chk #(
    .NUM_PORTS (NUM_PORTS),
    .PORT_W    (PORT_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .desc_valid (desc_valid),
    .desc_ready (desc_ready),
    .desc_src   (desc_src),
    .desc_flood (desc_flood),
    .desc_bcast (desc_bcast),
    .egr_valid  (egr_valid),
    .egr_ready  (egr_ready),
    .egr_mask   (egr_mask),
    .egr_drop   (egr_drop)
);

// File: tb/vlan_egress_filter_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench for vlan_egress_filter: driver tasks push expected
// results computed from a model of the requirements; a monitor pops them.
module vlan_egress_filter_tb_top;

    localparam int NP = 3;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [NP-1:0] cfg_wdata = '0;
    logic          desc_valid = 1'b0;
    logic          desc_ready;
    logic [1:0]    desc_src = '0;
    logic [1:0]    desc_dst = '0;
    logic          desc_flood = 1'b0;
    logic          desc_bcast = 1'b0;
    logic          egr_valid;
    logic          egr_ready = 1'b1;
    logic [NP-1:0] egr_mask;
    logic          egr_drop;

    always #4 clk = ~clk;

    vlan_egress_filter #(.NUM_PORTS(NP), .CFG_AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .desc_valid(desc_valid), .desc_ready(desc_ready),
        .desc_src(desc_src), .desc_dst(desc_dst), .desc_flood(desc_flood),
        .desc_bcast(desc_bcast), .egr_valid(egr_valid), .egr_ready(egr_ready),
        .egr_mask(egr_mask), .egr_drop(egr_drop)
    );

    typedef struct {
        logic [NP-1:0] mask;
        logic          drop;
        string         req;
    } exp_t;

    exp_t          sb[$];
    int            checks = 0;
    int            errors = 0;
    bit            done = 1'b0;
    logic [NP-1:0] m_mask [NP];
    logic          m_iso;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Model of the requirements for one descriptor.
    function automatic void model(input int s, input int d, input bit multi,
                                  output logic [NP-1:0] m, output logic dr);
        m = '0;
        if (s < NP) begin
            if (multi) begin
                m = m_mask[s] & ~(NP'(1) << s);
            end else if (d < NP && d != s) begin
                if (m_mask[s][d] || !m_iso) m = NP'(1) << d;
            end
        end
        dr = (m == '0);
    endfunction

    task automatic send(input int s, input int d, input bit fl, input bit bc,
                        input string req);
        exp_t e;
        @(negedge clk);
        desc_valid = 1'b1;
        desc_src   = 2'(s);
        desc_dst   = 2'(d);
        desc_flood = fl;
        desc_bcast = bc;
        while (!desc_ready) @(negedge clk);
        model(s, d, fl || bc, e.mask, e.drop);
        e.req = req;
        sb.push_back(e);
        @(negedge clk);
        desc_valid = 1'b0;
    endtask

    task automatic cfg_write(input int a, input logic [NP-1:0] v);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = AW'(a);
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        if (a < NP) m_mask[a] = v;
        else if (a == NP) m_iso = v[0];
    endtask

    // Write and descriptor in the same cycle: the descriptor sees old state.
    task automatic write_and_send(input int a, input logic [NP-1:0] v,
                                  input int s, input int d, input string req);
        exp_t e;
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = AW'(a); cfg_wdata = v;
        desc_valid = 1'b1; desc_src = 2'(s); desc_dst = 2'(d);
        desc_flood = 1'b0; desc_bcast = 1'b0;
        check(desc_ready == 1'b1, req, "ready for same-cycle write", int'(desc_ready), 1);
        model(s, d, 1'b0, e.mask, e.drop);
        e.req = req;
        sb.push_back(e);
        @(negedge clk);
        cfg_we = 1'b0; desc_valid = 1'b0;
        if (a < NP) m_mask[a] = v;
        else if (a == NP) m_iso = v[0];
    endtask

    // Monitor: compare each delivered result with the scoreboard head.
    always begin
        @(negedge clk);
        #2;
        if (rst_n && egr_valid && egr_ready) begin
            if (sb.size() == 0) begin
                check(1'b0, "R9", "unexpected result", int'(egr_mask), -1);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(egr_mask == e.mask, e.req, "egress mask", int'(egr_mask), int'(e.mask));
                check(egr_drop == e.drop, "R7", "drop flag", int'(egr_drop), int'(e.drop));
            end
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            check(1'b0, "R9", "watchdog expired", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        m_mask[0] = 3'b101; m_mask[1] = 3'b110; m_mask[2] = 3'b111;
        m_iso = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check(egr_valid == 1'b0, "R9", "reset egr_valid", int'(egr_valid), 0);
        check(desc_ready == 1'b1, "R9", "reset desc_ready", int'(desc_ready), 1);

        // R1 / R2 defaults seen through flooding
        send(0, 0, 1, 0, "R1");
        send(1, 0, 1, 0, "R1");
        send(2, 0, 1, 0, "R2");
        send(2, 1, 0, 1, "R2");
        // R3 unicast inside the mask
        send(0, 2, 0, 0, "R3");
        send(2, 0, 0, 0, "R3");
        send(2, 1, 0, 0, "R3");
        // R4 isolation on
        send(0, 1, 0, 0, "R4");
        send(1, 0, 0, 0, "R4");
        // R6 self-addressed
        send(1, 1, 0, 0, "R6");
        // R10 index out of range
        send(0, 3, 0, 0, "R10");
        send(3, 2, 0, 0, "R10");
        send(3, 0, 1, 0, "R10");

        // R8 control write, R5 unicast across VLANs now passes
        cfg_write(NP, 3'b000);
        send(0, 1, 0, 0, "R5");
        send(0, 1, 0, 1, "R2");
        // R8 mask write
        cfg_write(0, 3'b011);
        send(0, 0, 1, 0, "R8");
        send(0, 2, 0, 0, "R5");
        // R8 same-cycle write uses old control, next descriptor uses new
        write_and_send(NP, 3'b001, 0, 2, "R8");
        send(0, 2, 0, 0, "R4");
        // R8 write to unused address is ignored
        cfg_write(5, 3'b000);
        send(1, 0, 1, 0, "R8");
        send(2, 0, 1, 0, "R8");

        // R9 latency: result visible the cycle after acceptance
        @(negedge clk);
        egr_ready = 1'b0;
        send(2, 0, 0, 0, "R9");
        #1;
        check(egr_valid == 1'b1, "R9", "result one cycle after accept", int'(egr_valid), 1);
        // R9 hold while stalled
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); #1;
            check(egr_valid == 1'b1 && egr_mask == 3'b001, "R9", "held mask",
                  int'(egr_mask), 1);
            check(desc_ready == 1'b0, "R9", "ready low while stalled", int'(desc_ready), 0);
        end
        @(negedge clk);
        egr_ready = 1'b1;
        send(1, 2, 0, 0, "R3");
        repeat (4) @(negedge clk);
        #3;
        check(sb.size() == 0, "R9", "scoreboard drained", sb.size(), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule